// File: doc/BRIEF.md
# Asynchronous Serial Port with Shared Data Register

This block is a full-duplex asynchronous serial port behind a small 8-bit register interface. A single data address serves both directions. A write to it loads the transmit shift register and starts one outgoing frame. A read from it returns the receive buffer. A mode register sets the data length (7 or 8 bits), the parity scheme and the number of stop bits. A status register reports receive errors and shows whether a transmission is running.

Both directions take their timing from an external `tick` input, which pulses at 16 times the bit rate. One bit lasts 16 ticks on the line. The receiver detects a start bit and checks it again half a bit later. It then samples each later bit at its centre. The receive shift register cannot be seen through the register interface. Its contents reach the buffer only once the first stop bit has been sampled.

Register map: address 0 is data, address 1 is mode, address 2 is status. Address 3 reads as zero. A read is a cycle with `cs` high and `we` low, and its side effects take place on that clock edge.

Top module: `uart_shared_port`

## Requirements
- R1: A write to address 0 while idle starts a frame on `txd` at once. The frame is a low start bit, then the data bits LSB first, then high stop bits. Each bit lasts 16 ticks, and the line rests high when idle.
- R2: A read of address 0 returns the receive buffer. A write to address 0 leaves the receive buffer unchanged.
- R3: After reset `txd` is high, and the mode (address 1) and status (address 2) registers both read 0x00. The receive buffer has no defined reset value.
- R4: When mode bit 0 is 0 (7-bit data), only bits 0–6 of the written byte go out as data bits. Bit 7 is not sent.
- R5: In 7-bit mode a received character is stored in bits 0–6 of the receive buffer, and bit 7 reads 0.
- R6: Mode bits [2:1] pick the parity: 00 none, 01 even, 10 odd, 11 a parity bit that is always 0. The parity bit follows the last data bit and covers only the data bits that are sent.
- R7: A received parity bit that does not match the selected scheme sets status bit 0.
- R8: A low first stop bit sets status bit 1. The character is still stored.
- R9: A new character that arrives while the previous one has not yet been read from address 0 sets status bit 2. The buffer takes the new character.
- R10: A write to address 0 while a frame is being sent is ignored. The running frame goes on unchanged.
- R11: Status bit 3 is 1 from the write that starts a frame until the end of its last stop bit, and 0 otherwise.
- R12: A low pulse on `rxd` that has ended before the mid-start check is rejected. It stores no character and sets no flag.
- R13: Mode bit 3 set sends two stop bits, and the frame runs 16 ticks longer.
- R14: A read of address 2 clears status bits 0–2. A flag raised on the same edge is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable pulse at 16× the bit rate |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The hardest case to reach from the ports is a false start. The receive line must fall and rise again before the mid-bit recheck, which falls eight ticks after detection. The bench drives `rxd` low for only a few ticks, waits longer than a full character, and then reads the status and the data. Overrun also needs deliberate setup. Two complete characters are driven back to back while the data address is left unread. The same holds for a write that lands while a frame is running: it is issued on the cycle just after the starting write.

// File: rtl/uart_shared_port.sv
module uart_shared_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cs,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd
);
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_state_t;

  logic [3:0] mode;
  wire        len8  = mode[0];
  wire  [1:0] pmode = mode[2:1];
  wire        stop2 = mode[3];
  wire        pen   = (pmode != 2'b00);
  wire  [3:0] dbits = len8 ? 4'd8 : 4'd7;

  wire dwr = cs &  we & (addr == 2'd0);
  wire mwr = cs &  we & (addr == 2'd1);
  wire drd = cs & ~we & (addr == 2'd0);
  wire srd = cs & ~we & (addr == 2'd2);

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] pm);
    case (pm)
      2'b01:   par_of = ^d;
      2'b10:   par_of = ~^d;
      default: par_of = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= 4'd0;
    else if (mwr) mode <= wdata[3:0];

  // transmit
  logic [11:0] tx_sh, frame;
  logic [3:0]  tx_cnt, tx_div, nbits;
  logic [7:0]  tdat;
  logic        busy;

  always_comb begin
    tdat = len8 ? wdata : {1'b0, wdata[6:0]};
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(dbits)) frame[i+1] = tdat[i];
    if (pen) frame[dbits + 4'd1] = par_of(tdat, pmode);
    nbits = 4'd1 + dbits + {3'b0, pen} + (stop2 ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '1; tx_cnt <= '0; tx_div <= '0; busy <= 1'b0;
    end else if (dwr && !busy) begin
      tx_sh <= frame; tx_cnt <= nbits; tx_div <= '0; busy <= 1'b1;
    end else if (busy && tick) begin
      tx_div <= tx_div + 4'd1;
      if (tx_div == 4'd15) begin
        tx_sh  <= {1'b1, tx_sh[11:1]};
        tx_cnt <= tx_cnt - 4'd1;
        if (tx_cnt == 4'd1) busy <= 1'b0;
      end
    end

  assign txd = tx_sh[0];

  // receive
  logic [1:0] rsync;
  wire        rs = rsync[1];
  rx_state_t  rx_st;
  logic [3:0] rx_div, rx_idx;
  logic [8:0] rx_sh;
  logic [7:0] rxb, rx_dat;
  logic       rx_full, pe, fe, ovr, rx_perr;

  wire [3:0] last_idx = dbits + {3'b0, pen};
  wire       rx_samp  = (rx_st == R_BITS) && tick && (rx_div == 4'd15);
  wire       rx_load  = rx_samp && (rx_idx == last_idx);

  always_comb begin
    rx_dat  = len8 ? rx_sh[7:0] : {1'b0, rx_sh[6:0]};
    rx_perr = pen && (rx_sh[dbits] != par_of(rx_dat, pmode));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsync <= 2'b11; rx_st <= R_IDLE; rx_div <= '0; rx_idx <= '0; rx_sh <= '0;
      rx_full <= 1'b0; pe <= 1'b0; fe <= 1'b0; ovr <= 1'b0;
    end else begin
      rsync <= {rsync[0], rxd};
      if (srd) begin pe <= 1'b0; fe <= 1'b0; ovr <= 1'b0; end
      if (drd) rx_full <= 1'b0;
      if (tick)
        case (rx_st)
          R_IDLE: if (!rs) begin rx_st <= R_START; rx_div <= '0; end
          R_START: begin
            rx_div <= rx_div + 4'd1;
            if (rx_div == 4'd7) begin
              rx_div <= '0; rx_idx <= '0;
              rx_st  <= rs ? R_IDLE : R_BITS;
            end
          end
          default: begin
            rx_div <= rx_div + 4'd1;
            if (rx_div == 4'd15) begin
              if (rx_idx == last_idx) begin
                rx_st <= R_IDLE;
                if (rx_perr) pe  <= 1'b1;
                if (!rs)     fe  <= 1'b1;
                if (rx_full) ovr <= 1'b1;
                rx_full <= 1'b1;
              end else begin
                rx_sh[rx_idx] <= rs;
                rx_idx <= rx_idx + 4'd1;
              end
            end
          end
        endcase
    end

  always_ff @(posedge clk)
    if (rx_load) rxb <= rx_dat;

  always_comb
    case (addr)
      2'd0:    rdata = rxb;
      2'd1:    rdata = {4'b0, mode};
      2'd2:    rdata = {4'b0, busy, ovr, fe, pe};
      default: rdata = 8'h00;
    endcase

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dwr && !(tick && tx_div == 4'd15)) |=> ($stable(tx_sh) && busy));
  p_msb_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && !len8) |=> !rxb[7]);
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rx_full) |=> ovr);
  p_frame_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && !rs) |=> fe);
  p_clear_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (srd && !rx_load) |=> !(pe || fe || ovr));
endmodule

// File: tb/uart_shared_port_test.sv
module uart_shared_port_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cs = 1'b0, we = 1'b0, rxd = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic txd;
  int checks = 0, fails = 0;
  bit done = 0;

  uart_shared_port uut (.clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd));

  always #4 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a; #1 d = rdata;
    @(posedge clk); #1 cs = 0;
  endtask

  function automatic logic [11:0] mk_frame(logic [7:0] d, logic l8, logic [1:0] pm,
                                            output int n);
    logic [11:0] f = '1;
    int nd = l8 ? 8 : 7;
    int ones = 0;
    f[0] = 0;
    for (int i = 0; i < nd; i++) begin f[i+1] = d[i]; ones += d[i]; end
    n = 1 + nd + 1;
    if (pm != 0) begin
      f[nd+1] = (pm == 1) ? ones[0] : (pm == 2) ? ~ones[0] : 1'b0;
      n++;
    end
    return f;
  endfunction

  task automatic cap_tx(int n, output logic [11:0] b);
    b = '1;
    for (int k = 0; k < 400 && txd; k++) @(negedge clk);
    repeat (16) @(negedge clk);
    b[0] = txd;
    for (int i = 1; i < n; i++) begin repeat (32) @(negedge clk); b[i] = txd; end
  endtask

  task automatic rx_send(logic [11:0] bits, int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rxd = bits[i]; repeat (31) @(negedge clk); end
    @(negedge clk); rxd = 1;
    repeat (64) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R3 txd idle", txd, 1);
    rd(2'd1, v); chk("R3 mode", v, 8'h00);
    rd(2'd2, v); chk("R3 status", v, 8'h00);
  endtask

  task automatic t_tx(string req, logic [3:0] m, logic [7:0] d);
    logic [11:0] got, exp; int n; logic [7:0] v;
    wr(2'd1, {4'b0, m});
    exp = mk_frame(d, m[0], m[2:1], n);
    if (m[3]) n++;
    wr(2'd0, d);
    rd(2'd2, v); chk({req, " R11 busy set"}, v[3], 1);
    cap_tx(n, got);
    chk(req, got, exp);
    rd(2'd2, v); chk({req, " R11 busy at last stop"}, v[3], 1);
    repeat (64) @(negedge clk);
    rd(2'd2, v); chk({req, " R11 busy clear"}, v[3], 0);
  endtask

  task automatic t_ignore;
    logic [11:0] got, exp; int n;
    wr(2'd1, 8'h01);
    exp = mk_frame(8'h3C, 1, 0, n);
    wr(2'd0, 8'h3C);
    wr(2'd0, 8'hFF);
    cap_tx(n, got);
    chk("R10 write during frame ignored", got, exp);
    repeat (64) @(negedge clk);
  endtask

  task automatic t_rx8;
    logic [7:0] v; int n;
    wr(2'd1, 8'h01);
    rx_send(mk_frame(8'hDA, 1, 0, n), n);
    rd(2'd2, v); chk("R7 no error on good char", v, 8'h00);
    wr(2'd0, 8'h11);
    rd(2'd0, v); chk("R2 read returns buffer after data write", v, 8'hDA);
    repeat (400) @(negedge clk);
  endtask

  task automatic t_rx7;
    logic [7:0] v; int n;
    wr(2'd1, 8'h00);
    rx_send(mk_frame(8'h7F, 0, 0, n), n);
    rd(2'd0, v); chk("R5 7-bit char, bit 7 zero", v, 8'h7F);
  endtask

  task automatic t_perr;
    logic [7:0] v; logic [11:0] f; int n;
    wr(2'd1, 8'h03);
    f = mk_frame(8'h01, 1, 1, n);
    f[9] = ~f[9];
    rx_send(f, n);
    rd(2'd2, v); chk("R7 parity error flag", v, 8'h01);
    rd(2'd2, v); chk("R14 flags cleared by status read", v, 8'h00);
    rd(2'd0, v); chk("R7 char still stored", v, 8'h01);
  endtask

  task automatic t_ferr;
    logic [7:0] v; logic [11:0] f; int n;
    wr(2'd1, 8'h01);
    f = mk_frame(8'h55, 1, 0, n);
    f[9] = 0;
    rx_send(f, n);
    rd(2'd2, v); chk("R8 framing error flag", v, 8'h02);
    rd(2'd0, v); chk("R8 char stored", v, 8'h55);
  endtask

  task automatic t_ovr;
    logic [7:0] v; int n;
    wr(2'd1, 8'h01);
    rx_send(mk_frame(8'h11, 1, 0, n), n);
    rx_send(mk_frame(8'h22, 1, 0, n), n);
    rd(2'd2, v); chk("R9 overrun flag", v, 8'h04);
    rd(2'd0, v); chk("R9 buffer holds newer char", v, 8'h22);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    @(negedge clk); rxd = 0;
    repeat (8) @(negedge clk); rxd = 1;
    repeat (500) @(negedge clk);
    rd(2'd2, v); chk("R12 no flags after false start", v, 8'h00);
    rd(2'd0, v); chk("R12 buffer unchanged after false start", v, 8'h22);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_tx("R1 8N1 frame", 4'h1, 8'hA5);
    t_tx("R4 R6 7-bit even parity", 4'h2, 8'hC3);
    t_tx("R6 8-bit odd parity", 4'h5, 8'h0F);
    t_tx("R6 8-bit zero parity", 4'h7, 8'hFF);
    t_tx("R13 two stop bits", 4'h9, 8'h00);
    t_ignore;
    t_rx8;
    t_rx7;
    t_perr;
    t_ferr;
    t_ovr;
    t_glitch;
    done = 1;
    report;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report;
    end
  end
endmodule